// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

This block sits between a processor's load/store port and a word-wide memory port. It keeps recently used 64-byte lines in a 4-way set-associative array of 256 lines (64 sets). Each 32-bit byte address is cut into a word-within-line offset, a set index and a tag. The four ways of the selected set are compared in parallel. Loads and stores that hit are served from the array. Stores mark their line as modified, and memory is not touched.

On a miss the controller picks a victim way. An empty way is taken first. If the set is full, the way comes from a free-running pseudo-random source. A victim that holds modified data is copied back to memory word by word. The missing line is then fetched word by word, and the original access completes against the refilled line. Stores allocate on a miss. While a miss is serviced, the processor side is held off.

Top module: `wb_dcache`

## Requirements
- R1: The address splits into offset bits [OFF_W-1:0] (word within line at [OFF_W-1:2]), set index [OFF_W+IDX_W-1:OFF_W] and tag [31:OFF_W+IDX_W], where OFF_W = log2(LINE_BYTES) and IDX_W = log2(SETS). Two addresses in the same line hit the same entry.
- R2: After reset every line is invalid. `cpu_ready` is 1, `cpu_done` is 0 and `mem_req` is 0, and the first access to any address misses.
- R3: All ways of the indexed set are tag-compared in the same cycle, and at most one way matches.
- R4: A read hit accepted in cycle T raises `cpu_done` in cycle T+1, with `cpu_rdata` holding the latest value written to that address.
- R5: A write hit updates the word in the array, marks the line modified and causes no memory traffic.
- R6: On a miss where the set has an invalid way, that way is filled, no write-back occurs and the resident lines of the set stay resident.
- R7: On a miss in a full set, a pseudo-randomly chosen way is evicted. If and only if that way is modified, its LINE_BYTES/4 words are first written to memory at the old tag's line address, carrying the latest data.
- R8: A refill reads LINE_BYTES/4 words from the line-aligned address in ascending word order, then completes the original read or write (write-allocate).
- R9: `cpu_ready` goes low in the cycle after a missing request is accepted and stays low until the cycle in which `cpu_done` for that request is 1.
- R10: A memory word moves only in a cycle with `mem_req` and `mem_ready` both 1. While `mem_ready` is 0, `mem_req` and `mem_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = word write, 0 = read |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Cache can take a request this cycle |
| cpu_done | output | 1 | One-cycle pulse: access finished |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` on a read |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, valid while `mem_ready` is 1 |
| mem_ready | input | 1 | Word transferred this cycle |

## Verification
The bench builds the cache with 4 ways, 4 sets and 16-byte lines. With four words per line and only four sets, a handful of addresses fill a set completely. This makes both clean and modified evictions, write-back address and data checks, and repeated stall windows cheap to reach. Memory answers on every other cycle, so the hold rules on the memory port are exercised on every line transfer.

// File: rtl/wb_dcache_pkg.sv
package wb_dcache_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WBACK  = 2'd1,
        ST_FILL   = 2'd2,
        ST_REPLAY = 2'd3
    } ctl_state_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cpu_op_t;

    function automatic logic [7:0] lfsr_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/wb_dcache_tags.sv
module wb_dcache_tags #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned SETS  = 64,
    parameter int unsigned TAG_W = 20,
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [IDX_W-1:0]            lk_idx,
    input  logic [TAG_W-1:0]            lk_tag,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [WAYS-1:0]             valid_vec,
    output logic [WAYS-1:0]             dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]  way_tags,
    input  logic                        fill_en,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        dirty_en,
    input  logic [WAY_W-1:0]            dirty_way
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign way_tags[g]  = tag_q[lk_idx][g];
        assign valid_vec[g] = valid_q[lk_idx][g];
        assign dirty_vec[g] = dirty_q[lk_idx][g];
        assign hit_vec[g]   = valid_q[lk_idx][g] && (tag_q[lk_idx][g] == lk_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end
    assign hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (fill_en) begin
            tag_q[lk_idx][fill_way]   <= fill_tag;
            valid_q[lk_idx][fill_way] <= 1'b1;
            dirty_q[lk_idx][fill_way] <= 1'b0;
        end else if (dirty_en) begin
            dirty_q[lk_idx][dirty_way] <= 1'b1;
        end
    end

    // R3: parallel compare never yields two matching ways
    p_single_hit_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R7: a line can only be modified while it is resident
    p_dirty_implies_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (dirty_vec & ~valid_vec) == '0);
endmodule

// File: rtl/wb_dcache_data.sv
module wb_dcache_data #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned SETS   = 64,
    parameter int unsigned WORDS  = 16,
    localparam int unsigned WAY_W  = $clog2(WAYS),
    localparam int unsigned IDX_W  = $clog2(SETS),
    localparam int unsigned WORD_W = $clog2(WORDS),
    localparam int unsigned DEPTH  = WAYS * SETS * WORDS
) (
    input  logic              clk,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    output logic [31:0]       rd_data,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [31:0]       wr_data
);
    logic [31:0] store_q [DEPTH];

    assign rd_data = store_q[{rd_way, rd_idx, rd_word}];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[{wr_way, wr_idx, wr_word}] <= wr_data;
    end
endmodule

// File: rtl/wb_dcache_victim.sv
module wb_dcache_victim
    import wb_dcache_pkg::*;
#(
    parameter int unsigned WAYS = 4,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WAYS-1:0]  valid_vec,
    output logic [WAY_W-1:0] pick
);
    logic [7:0] lfsr_q;
    logic       found;

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= 8'h01;
        else     lfsr_q <= lfsr_next(lfsr_q);
    end

    always_comb begin
        pick  = lfsr_q[WAY_W-1:0];
        found = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!found && !valid_vec[i]) begin
                pick  = WAY_W'(i);
                found = 1'b1;
            end
        end
    end

    // R6: an empty way is always preferred over evicting a resident line
    p_invalid_first_r6: assert property (@(posedge clk) disable iff (rst)
        (!(&valid_vec)) |-> !valid_vec[pick]);

    // R7: the pseudo-random source never locks up
    p_lfsr_alive_r7: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != 8'h00);
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
    import wb_dcache_pkg::*;
#(
    parameter int unsigned WAYS       = 4,
    parameter int unsigned SETS       = 64,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic        cpu_done,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready
);
    localparam int unsigned WAY_W  = $clog2(WAYS);
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned WORDS  = LINE_BYTES / 4;
    localparam int unsigned WORD_W = OFF_W - 2;
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

    ctl_state_t        state_q;
    cpu_op_t           op_q;
    logic [WAY_W-1:0]  vic_q;
    logic [TAG_W-1:0]  vic_tag_q;
    logic [WORD_W-1:0] cnt_q;
    logic              done_q;
    logic [31:0]       rdata_q;

    logic [31:0]       lk_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WORD_W-1:0] lk_word;
    logic [WAYS-1:0]   hit_vec, valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0] way_tags;
    logic              hit;
    logic [WAY_W-1:0]  hit_way, pick;
    logic              accept, do_hit, acc_we;
    logic [31:0]       acc_wdata, rd_data;
    logic              fill_wr, fill_last, vic_dirty;

    assign lk_addr = (state_q == ST_IDLE) ? cpu_addr : op_q.addr;
    assign lk_idx  = lk_addr[OFF_W +: IDX_W];
    assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
    assign lk_word = lk_addr[2 +: WORD_W];

    assign accept    = (state_q == ST_IDLE) && cpu_req;
    assign do_hit    = (accept && hit) || (state_q == ST_REPLAY);
    assign acc_we    = (state_q == ST_IDLE) ? cpu_we    : op_q.we;
    assign acc_wdata = (state_q == ST_IDLE) ? cpu_wdata : op_q.wdata;
    assign fill_wr   = (state_q == ST_FILL) && mem_ready;
    assign fill_last = fill_wr && (cnt_q == LAST_WORD);
    assign vic_dirty = valid_vec[pick] && dirty_vec[pick];

    wb_dcache_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (lk_idx),
        .lk_tag   (lk_tag),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_way  (hit_way),
        .valid_vec(valid_vec),
        .dirty_vec(dirty_vec),
        .way_tags (way_tags),
        .fill_en  (fill_last),
        .fill_way (vic_q),
        .fill_tag (lk_tag),
        .dirty_en (do_hit && acc_we),
        .dirty_way(hit_way)
    );

    wb_dcache_victim #(.WAYS(WAYS)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .valid_vec(valid_vec),
        .pick     (pick)
    );

    wb_dcache_data #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)) u_data (
        .clk    (clk),
        .rd_way ((state_q == ST_WBACK) ? vic_q : hit_way),
        .rd_idx (lk_idx),
        .rd_word((state_q == ST_WBACK) ? cnt_q : lk_word),
        .rd_data(rd_data),
        .wr_en  (fill_wr || (do_hit && acc_we)),
        .wr_way (fill_wr ? vic_q : hit_way),
        .wr_idx (lk_idx),
        .wr_word(fill_wr ? cnt_q : lk_word),
        .wr_data(fill_wr ? mem_rdata : acc_wdata)
    );

    assign cpu_ready = (state_q == ST_IDLE);
    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;
    assign mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
    assign mem_we    = (state_q == ST_WBACK);
    assign mem_wdata = rd_data;
    assign mem_addr  = (state_q == ST_WBACK) ? {vic_tag_q, lk_idx, cnt_q, 2'b00}
                                             : {lk_tag,    lk_idx, cnt_q, 2'b00};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            vic_q     <= '0;
            vic_tag_q <= '0;
            cnt_q     <= '0;
            done_q    <= 1'b0;
            rdata_q   <= '0;
        end else begin
            done_q <= do_hit;
            if (do_hit && !acc_we) rdata_q <= rd_data;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && !hit) begin
                        op_q      <= '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
                        vic_q     <= pick;
                        vic_tag_q <= way_tags[pick];
                        cnt_q     <= '0;
                        state_q   <= vic_dirty ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: begin
                    if (mem_ready) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST_WORD) state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ready) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST_WORD) state_q <= ST_REPLAY;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: a hitting request completes on the next cycle
    p_hit_done_next_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> cpu_done);

    // R5: no memory traffic while the controller is serving hits
    p_no_mem_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !mem_req);

    // R7: a clean or empty victim goes straight to refill
    p_clean_skips_wb_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit && !vic_dirty) |=> (state_q == ST_FILL));

    // R8: after the refill the replayed access finds its line
    p_replay_hits_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REPLAY) |-> hit);

    // R9: a missing request drops ready on the following cycle
    p_miss_stalls_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit) |=> !cpu_ready);

    // R10: a pending memory word holds its request and address
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/tb_wb_dcache.sv
module tb_wb_dcache;
    localparam int WAYS = 4;
    localparam int SETS = 4;
    localparam int LINE_BYTES = 16;
    localparam int WORDS = LINE_BYTES / 4;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_done;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;

    int total = 0;
    int bad = 0;
    int wb_words = 0;
    int wb_err = 0;
    int fill_err = 0;
    logic [31:0] wb_first;
    logic [31:0] bmem    [256];
    logic [31:0] exp_mem [256];
    logic [7:0]  fill_next = '0;

    always #(HALF) clk = ~clk;

    wb_dcache #(.WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LINE_BYTES)) dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    assign mem_rdata = bmem[mem_addr[9:2]];

    // memory model: answers every other cycle; logs write-back and refill order
    always @(posedge clk) begin
        mem_ready <= ~mem_ready;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                if (wb_words == 0) wb_first = mem_addr;
                if (mem_wdata !== exp_mem[mem_addr[9:2]]) wb_err = wb_err + 1;
                bmem[mem_addr[9:2]] <= mem_wdata;
                wb_words = wb_words + 1;
            end else begin
                if (mem_addr[3:2] != fill_next[1:0]) fill_err = fill_err + 1;
                fill_next = fill_next + 8'd1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // hit_exp / wb_exp: 0 or 1, 2 = not checked
    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          input int hit_exp, input int wb_exp, input string req);
        int lat = 1;
        int stall_bad = 0;
        int wb0;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        wb0 = wb_words;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        if (we) exp_mem[addr[9:2]] = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_done) begin
            if (cpu_ready) stall_bad++;
            @(negedge clk);
            lat++;
        end
        if (!we) check(cpu_rdata === exp_mem[addr[9:2]], {req, " data"}, cpu_rdata, exp_mem[addr[9:2]]);
        if (hit_exp != 2) check((lat == 1) == (hit_exp == 1), {req, " hit/miss"}, 32'(lat), 32'(hit_exp));
        if (wb_exp != 2) check((wb_words - wb0) == wb_exp * WORDS, {req, " write-back count"},
                               32'(wb_words - wb0), 32'(wb_exp * WORDS));
        if (lat > 1) check(stall_bad == 0, "R9 ready low during miss", 32'(stall_bad), 32'd0);
    endtask

    // {we, addr, wdata, hit_exp[1:0], wb_exp[1:0]}
    localparam logic [68:0] VEC [12] = '{
        {1'b0, 32'h000, 32'h0,         2'd0, 2'd0},  // R2 empty: first access misses
        {1'b0, 32'h004, 32'h0,         2'd1, 2'd0},  // R1 same line, other word
        {1'b1, 32'h008, 32'h1111_2222, 2'd1, 2'd0},  // R5 write hit, no traffic
        {1'b0, 32'h008, 32'h0,         2'd1, 2'd0},  // R4 read back written word
        {1'b0, 32'h040, 32'h0,         2'd0, 2'd0},  // R6 second way of set 0
        {1'b0, 32'h080, 32'h0,         2'd0, 2'd0},  // R6 third way
        {1'b1, 32'h0C4, 32'h3333_4444, 2'd0, 2'd0},  // R8 write-allocate miss
        {1'b0, 32'h0C4, 32'h0,         2'd1, 2'd0},  // R8 allocated word readable
        {1'b0, 32'h010, 32'h0,         2'd0, 2'd0},  // R1 index bits pick set 1
        {1'b0, 32'h000, 32'h0,         2'd1, 2'd0},  // R6 earlier lines kept
        {1'b0, 32'h04C, 32'h0,         2'd1, 2'd0},  // R6
        {1'b0, 32'h08C, 32'h0,         2'd1, 2'd0}   // R3 one matching way
    };

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i]    = 32'h5A00_0000 + 32'(i) * 32'h0001_0003;
            exp_mem[i] = 32'h5A00_0000 + 32'(i) * 32'h0001_0003;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_ready === 1'b1, "R2 ready after reset", 32'(cpu_ready), 32'd1);
        check(cpu_done === 1'b0, "R2 done idle after reset", 32'(cpu_done), 32'd0);
        check(mem_req === 1'b0, "R2 no memory request after reset", 32'(mem_req), 32'd0);

        for (int v = 0; v < 12; v++) begin
            access(VEC[v][68], VEC[v][67:36], VEC[v][35:4], int'(VEC[v][3:2]), int'(VEC[v][1:0]),
                   $sformatf("R4/R6 vector %0d", v));
        end

        // R7 clean victim: fill set 3 with clean lines, then a fifth tag
        access(1'b0, 32'h030, 32'h0, 0, 0, "R6 set3 way");
        access(1'b0, 32'h070, 32'h0, 0, 0, "R6 set3 way");
        access(1'b0, 32'h0B0, 32'h0, 0, 0, "R6 set3 way");
        access(1'b0, 32'h0F0, 32'h0, 0, 0, "R6 set3 way");
        access(1'b0, 32'h130, 32'h0, 0, 0, "R7 clean eviction skips write-back");

        // R7 modified victim: all of set 2 modified, then a fifth tag
        access(1'b1, 32'h020, 32'hA0A0_0001, 0, 0, "R8 alloc set2");
        access(1'b1, 32'h064, 32'hA0A0_0002, 0, 0, "R8 alloc set2");
        access(1'b1, 32'h0A8, 32'hA0A0_0003, 0, 0, "R8 alloc set2");
        access(1'b1, 32'h0EC, 32'hA0A0_0004, 0, 0, "R8 alloc set2");
        access(1'b1, 32'h124, 32'hB0B0_0005, 0, 1, "R7 dirty eviction writes line back");
        check(wb_first[5:0] == 6'h20 && wb_first[31:10] == '0 &&
              (wb_first[9:6] <= 4'h3), "R7 write-back at old line address", wb_first, 32'h20);
        check(wb_err == 0, "R7 write-back data is latest", 32'(wb_err), 32'd0);

        access(1'b0, 32'h020, 32'h0, 2, 2, "R7 set2 data after eviction");
        access(1'b0, 32'h064, 32'h0, 2, 2, "R7 set2 data after eviction");
        access(1'b0, 32'h0A8, 32'h0, 2, 2, "R7 set2 data after eviction");
        access(1'b0, 32'h0EC, 32'h0, 2, 2, "R7 set2 data after eviction");
        access(1'b0, 32'h124, 32'h0, 2, 2, "R8 allocated write survives");
        check(wb_err == 0, "R7 later write-backs carry latest data", 32'(wb_err), 32'd0);
        check(fill_err == 0, "R8 refill words ascend", 32'(fill_err), 32'd0);
        check(wb_words % WORDS == 0, "R10 whole lines written back", 32'(wb_words), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(2 * HALF * 150000);
        total++;
        bad++;
        $display("FAIL watchdog R9 actual=%h expected=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule